// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership tokens that two independent ports, called left and right, use to agree on who may use a shared resource. Each port has its own select, memory enable, read/write strobe, address and data bus. A port asks for a token by writing 0 to that token and gives it back by writing 1. A port that reads a token gets 0 when it holds the token and 1 when it does not. When a port asks for a token the other side already holds, the request waits, and ownership passes straight to it when the holder gives the token back.

Each token is a five-state machine. The states are `TOK_FREE`, `TOK_LEFT` (left holds it), `TOK_RIGHT` (right holds it), `TOK_LEFT_RWAIT` (left holds it, right is waiting) and `TOK_RIGHT_LWAIT` (right holds it, left is waiting).

The transitions are:
- From `TOK_FREE`: a left request goes to `TOK_LEFT`. A right request goes to `TOK_RIGHT`. Both requests together go to `TOK_LEFT_RWAIT`.
- From `TOK_LEFT`: a left release goes to `TOK_FREE`, or to `TOK_RIGHT` if right requests in the same cycle. A right request goes to `TOK_LEFT_RWAIT`.
- From `TOK_LEFT_RWAIT`: a left release hands the token over to `TOK_RIGHT`. A right cancel goes back to `TOK_LEFT`. Both together go to `TOK_FREE`.
- `TOK_RIGHT` and `TOK_RIGHT_LWAIT` follow the same rules with the two sides swapped.

Every read goes into a per-port output register. That register holds its value until the same port reads again.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is in `TOK_FREE` and both read registers hold all ones. Any later read of any token, from either port, returns all ones until a port writes.
- R2: An access takes place only when the port's select is 1 and its memory enable is 0. Any other combination leaves every token and that port's read register unchanged.
- R3: The token index is the low 3 address bits. All higher address bits are ignored.
- R4: A write looks only at data bit 0: 0 is a request and 1 is a release or a cancel. All other data bits are ignored.
- R5: When a free token is requested by one port only, that port then reads 0 and the other port reads 1 for that token.
- R6: A request from the port that does not hold the token does not take it. The holder keeps reading 0 and the requester keeps reading 1. A repeated request by the holder changes nothing.
- R7: When the holder writes 1 while the other port has a request waiting, or while the other port requests in the same cycle, the other port holds the token from the next cycle on.
- R8: When the holder writes 1 and no request from the other port is waiting, the token becomes free and both ports read 1.
- R9: A write of 1 by the waiting port cancels its request, so a later release by the holder frees the token. A write of 1 by a port that neither holds nor waits has no effect.
- R10: When both ports request a free token in the same cycle, left gets the token and right's request waits.
- R11: A read sampled at a clock edge returns the token state from before that edge, replicated on every data bit, in the cycle after the edge. The port's read register then keeps that value until the port's next read, whatever the other port writes.
- R12: Tokens are independent: an access to one index never changes any other token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; must be 0 for a semaphore access |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | ADDR_W | Left address; low 3 bits pick the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read value |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; must be 0 for a semaphore access |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_addr | input | ADDR_W | Right address; low 3 bits pick the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read value |

## Verification
The states that are hard to reach are the waiting states, `TOK_LEFT_RWAIT` and `TOK_RIGHT_LWAIT`. Reaching them needs a set order of writes from both ports. Leaving them needs a release and a cancel that may fall in the same cycle. The stimulus works through every token index and steps through every sequence of three cycles. In each cycle, each port either requests, releases, or makes a blocked access. A read-back follows every step, so every state is reached and every way of leaving it, including both ports acting at once, is checked against a token model kept in the bench. Each step puts junk in the upper address bits and upper data bits.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        TOK_FREE        = 3'd0,
        TOK_LEFT        = 3'd1,
        TOK_RIGHT       = 3'd2,
        TOK_LEFT_RWAIT  = 3'd3,
        TOK_RIGHT_LWAIT = 3'd4
    } tok_state_e;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              sel,
    input  logic              mem_en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec
);

    logic access_ok;
    logic wr_hit;
    logic unused_hi;

    // Semaphore space is open only while the memory array is deselected.
    assign access_ok = sel && !mem_en;
    assign rd_hit    = access_ok && !wr;
    assign wr_hit    = access_ok && wr;
    assign rd_idx    = addr[IDX_W-1:0];
    assign unused_hi = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    always_comb begin
        for (int k = 0; k < NUM_SEM; k++) begin
            req_vec[k] = wr_hit && !wdata[0] && (rd_idx == IDX_W'(k));
            rel_vec[k] = wr_hit &&  wdata[0] && (rd_idx == IDX_W'(k));
        end
    end

endmodule

// File: rtl/sem_token_fsm.sv
module sem_token_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_owns,
    output logic r_owns,
    output logic l_waits,
    output logic r_waits
);

    tok_state_e cur_q;
    tok_state_e nxt;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            TOK_FREE: begin
                if (l_req)      nxt = r_req ? TOK_LEFT_RWAIT : TOK_LEFT;
                else if (r_req) nxt = TOK_RIGHT;
            end
            TOK_LEFT: begin
                if (l_rel)      nxt = r_req ? TOK_RIGHT : TOK_FREE;
                else if (r_req) nxt = TOK_LEFT_RWAIT;
            end
            TOK_LEFT_RWAIT: begin
                if (l_rel)      nxt = r_rel ? TOK_FREE : TOK_RIGHT;
                else if (r_rel) nxt = TOK_LEFT;
            end
            TOK_RIGHT: begin
                if (r_rel)      nxt = l_req ? TOK_LEFT : TOK_FREE;
                else if (l_req) nxt = TOK_RIGHT_LWAIT;
            end
            TOK_RIGHT_LWAIT: begin
                if (r_rel)      nxt = l_rel ? TOK_FREE : TOK_LEFT;
                else if (l_rel) nxt = TOK_RIGHT;
            end
            default: nxt = TOK_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= TOK_FREE;
        else        cur_q <= nxt;
    end

    always_comb begin
        l_owns  = (cur_q == TOK_LEFT)  || (cur_q == TOK_LEFT_RWAIT);
        r_owns  = (cur_q == TOK_RIGHT) || (cur_q == TOK_RIGHT_LWAIT);
        l_waits = (cur_q == TOK_RIGHT_LWAIT);
        r_waits = (cur_q == TOK_LEFT_RWAIT);
    end

endmodule

// File: rtl/sem_read_latch.sv
module sem_read_latch #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_hit,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    // Captured value stays put until this port reads again.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '1;
        else if (rd_hit) rdata <= {DATA_W{!own_vec[rd_idx]}};
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic               l_rd_hit, r_rd_hit;
    logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;
    logic [NUM_SEM-1:0] l_req_v, l_rel_v, r_req_v, r_rel_v;
    logic [NUM_SEM-1:0] l_own_v, r_own_v, l_wait_v, r_wait_v;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
        .rd_hit(l_rd_hit), .rd_idx(l_rd_idx), .req_vec(l_req_v), .rel_vec(l_rel_v)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
        .rd_hit(r_rd_hit), .rd_idx(r_rd_idx), .req_vec(r_req_v), .rel_vec(r_rel_v)
    );

    for (genvar t = 0; t < NUM_SEM; t++) begin : g_tok
        sem_token_fsm u_tok (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req_v[t]), .l_rel(l_rel_v[t]),
            .r_req(r_req_v[t]), .r_rel(r_rel_v[t]),
            .l_owns(l_own_v[t]), .r_owns(r_own_v[t]),
            .l_waits(l_wait_v[t]), .r_waits(r_wait_v[t])
        );
    end

    sem_read_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_hit(l_rd_hit), .rd_idx(l_rd_idx),
        .own_vec(l_own_v), .rdata(l_rdata)
    );

    sem_read_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_hit(r_rd_hit), .rd_idx(r_rd_idx),
        .own_vec(r_own_v), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_rd_hit,
    input logic               r_rd_hit,
    input logic [NUM_SEM-1:0] l_req_v,
    input logic [NUM_SEM-1:0] l_rel_v,
    input logic [NUM_SEM-1:0] r_req_v,
    input logic [NUM_SEM-1:0] r_rel_v,
    input logic [NUM_SEM-1:0] l_own_v,
    input logic [NUM_SEM-1:0] r_own_v,
    input logic [NUM_SEM-1:0] r_wait_v,
    input logic [DATA_W-1:0]  l_rdata,
    input logic [DATA_W-1:0]  r_rdata
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_req_v == '0 && l_rel_v == '0 && r_req_v == '0 && r_rel_v == '0)
        |=> ($stable(l_own_v) && $stable(r_own_v)));

    // R11
    l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_hit |=> $stable(l_rdata));

    // R11
    r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd_hit |=> $stable(r_rdata));

    // R11
    rdata_replicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == {DATA_W{l_rdata[0]}}) && (r_rdata == {DATA_W{r_rdata[0]}}));

    for (genvar k = 0; k < NUM_SEM; k++) begin : g_chk
        // R5
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(l_own_v[k] && r_own_v[k]));

        // R6
        no_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_own_v[k] && l_req_v[k] && !r_rel_v[k]) |=> (r_own_v[k] && !l_own_v[k]));

        // R7
        handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (l_own_v[k] && r_wait_v[k] && l_rel_v[k] && !r_rel_v[k]) |=> r_own_v[k]);

        // R8
        release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (l_own_v[k] && !r_wait_v[k] && l_rel_v[k] && !r_req_v[k])
            |=> (!l_own_v[k] && !r_own_v[k]));

        // R10
        tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_own_v[k] && !r_own_v[k] && l_req_v[k] && r_req_v[k])
            |=> (l_own_v[k] && r_wait_v[k]));
    end

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_rd_hit(l_rd_hit), .r_rd_hit(r_rd_hit),
    .l_req_v(l_req_v), .l_rel_v(l_rel_v), .r_req_v(r_req_v), .r_rel_v(r_rel_v),
    .l_own_v(l_own_v), .r_own_v(r_own_v), .r_wait_v(r_wait_v),
    .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;

    localparam int NS = 8;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel = 0, l_mem_en = 0, l_wr = 0;
    logic          r_sel = 0, r_mem_en = 0, r_wr = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Bench token model: owner 0 none, 1 left, 2 right; pend = other side waiting.
    int    owner [NS];
    bit    pend  [NS];
    string rule  [NS];
    bit    exp_l = 1, exp_r = 1;

    always #2.5 clk = ~clk;

    sem_bank #(.NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) i_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic model_reset();
        for (int t = 0; t < NS; t++) begin
            owner[t] = 0; pend[t] = 0; rule[t] = "R1";
        end
        exp_l = 1; exp_r = 1;
    endtask

    task automatic model_apply(input bit lw, input int li, input bit ld,
                               input bit rw, input int ri, input bit rd);
        for (int t = 0; t < NS; t++) begin
            bit lq, ll, rq, rl;
            lq = lw && li == t && !ld;  ll = lw && li == t && ld;
            rq = rw && ri == t && !rd;  rl = rw && ri == t && rd;
            if (owner[t] == 0) begin
                if (lq) begin owner[t] = 1; pend[t] = rq; rule[t] = rq ? "R10" : "R5"; end
                else if (rq) begin owner[t] = 2; pend[t] = 0; rule[t] = "R5"; end
            end else if (owner[t] == 1) begin
                if (ll) begin
                    if ((pend[t] && !rl) || rq) begin owner[t] = 2; rule[t] = "R7"; end
                    else begin owner[t] = 0; rule[t] = "R8"; end
                    pend[t] = 0;
                end else if (rq) begin pend[t] = 1; rule[t] = "R6"; end
                else if (rl) begin pend[t] = 0; rule[t] = "R9"; end
                else if (lq) rule[t] = "R6";
            end else begin
                if (rl) begin
                    if ((pend[t] && !ll) || lq) begin owner[t] = 1; rule[t] = "R7"; end
                    else begin owner[t] = 0; rule[t] = "R8"; end
                    pend[t] = 0;
                end else if (lq) begin pend[t] = 1; rule[t] = "R6"; end
                else if (ll) begin pend[t] = 0; rule[t] = "R9"; end
                else if (rq) rule[t] = "R6";
            end
        end
    endtask

    task automatic drive(input int op, output logic s, output logic m, output logic w);
        // op: 0 idle, 1 read, 2 write, 3 write with memory enable high, 4 write unselected
        s = (op == 1 || op == 2 || op == 3);
        m = (op == 3);
        w = (op >= 2);
    endtask

    task automatic check(input string tag, input string side,
                         input logic [DW-1:0] act, input bit e);
        checks = checks + 1;
        if (act !== {DW{e}}) begin
            errors = errors + 1;
            $display("FAIL %s port %s: actual %h expected %h", tag, side, act, {DW{e}});
        end
    endtask

    task automatic step(input int lop, input logic [AW-1:0] la, input logic [DW-1:0] lw,
                        input int rop, input logic [AW-1:0] ra, input logic [DW-1:0] rw,
                        input string ltag, input string rtag);
        string tl, tr;
        drive(lop, l_sel, l_mem_en, l_wr);
        drive(rop, r_sel, r_mem_en, r_wr);
        l_addr = la; l_wdata = lw; r_addr = ra; r_wdata = rw;
        tl = "R11"; tr = "R11";
        if (lop == 1) begin
            exp_l = (owner[la[2:0]] != 1);
            tl = (ltag == "") ? rule[la[2:0]] : ltag;
        end
        if (rop == 1) begin
            exp_r = (owner[ra[2:0]] != 2);
            tr = (rtag == "") ? rule[ra[2:0]] : rtag;
        end
        @(posedge clk);
        model_apply(lop == 2, int'(la[2:0]), lw[0], rop == 2, int'(ra[2:0]), rw[0]);
        @(negedge clk);
        check(tl, "left", l_rdata, exp_l);
        check(tr, "right", r_rdata, exp_r);
    endtask

    task automatic do_reset();
        rst_n = 0;
        l_sel = 0; r_sel = 0; l_wr = 0; r_wr = 0; l_mem_en = 0; r_mem_en = 0;
        repeat (2) @(negedge clk);
        model_reset();
        check("R1", "left", l_rdata, 1'b1);
        check("R1", "right", r_rdata, 1'b1);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int t = 0; t < NS; t++)
            step(1, AW'(t), '0, 1, AW'(t), '0, tag, tag);
    endtask

    initial begin
        do_reset();
        read_all("R1");

        // R3: upper address bits ignored
        step(2, 16'hABC5, 16'h0000, 0, '0, '0, "", "");
        step(1, 16'h7FF5, '0, 1, 16'h0005, '0, "R3", "R3");
        // R4: only data bit 0 used
        step(2, 16'h0006, 16'hFFFE, 0, '0, '0, "", "");
        step(1, 16'h0006, '0, 1, 16'h1236, '0, "R4", "R4");
        step(2, 16'h0006, 16'h0001, 0, '0, '0, "", "");
        step(1, 16'h0006, '0, 1, 16'h0006, '0, "R4", "R4");
        // R2: blocked accesses change nothing
        step(3, 16'h0001, 16'h0000, 4, 16'h0001, 16'h0000, "", "");
        step(1, 16'h0001, '0, 1, 16'h0001, '0, "R2", "R2");
        step(3, 16'h0005, 16'hFFFF, 3, 16'h0005, 16'h0000, "", "");
        step(1, 16'h0005, '0, 1, 16'h0005, '0, "R2", "R2");
        // R12: other tokens untouched
        step(1, 16'h0004, '0, 1, 16'h0006, '0, "R12", "R12");

        // R11: left latches 0, right queues and takes over, left register holds
        step(2, 16'h0002, 16'h0000, 0, '0, '0, "", "");
        step(1, 16'h0002, '0, 0, '0, '0, "R11", "");
        step(0, '0, '0, 2, 16'h0002, 16'h0000, "", "");
        step(2, 16'h0002, 16'h0001, 0, '0, '0, "", "");
        step(0, '0, '0, 1, 16'h0002, '0, "", "R11");
        step(1, 16'h0002, '0, 1, 16'h0002, '0, "R11", "R7");

        // mid-run reset clears everything
        do_reset();
        read_all("R1");

        // Sweep: every index, every 3-step sequence of both-side actions
        for (int idx = 0; idx < NS; idx++) begin
            for (int a = 0; a < 9; a++)
            for (int b = 0; b < 9; b++)
            for (int c = 0; c < 9; c++) begin
                int acts [3];
                acts[0] = a; acts[1] = b; acts[2] = c;
                for (int s = 0; s < 3; s++) begin
                    int la_, ra_, lop, rop;
                    logic [AW-1:0] junk;
                    la_ = acts[s] % 3; ra_ = acts[s] / 3;
                    junk = AW'((cyc * 37 + s) << 3);
                    lop = (la_ == 0) ? ((s % 2 == 0) ? 3 : 4) : 2;
                    rop = (ra_ == 0) ? ((s % 2 == 0) ? 4 : 3) : 2;
                    step(lop, junk | AW'(idx), {junk[DW-2:0], (la_ != 1)},
                         rop, ~junk & ~AW'(7) | AW'(idx), {~junk[DW-2:0], (ra_ != 1)}, "", "");
                    step(1, junk | AW'(idx), '0, 1, AW'(idx), '0, "", "");
                end
                step(1, AW'((idx + 1) % NS), '0, 1, AW'((idx + 3) % NS), '0, "R12", "R12");
                step(2, AW'(idx), 16'h0001, 2, AW'(idx), 16'h0001, "", "");
                step(1, AW'(idx), '0, 1, AW'(idx), '0, "R8", "R8");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule